// File: doc/BRIEF.md
# Video DRAM Size Probe Sequencer

This block works out how much video DRAM is really fitted behind a display controller, either 16K or 64K. It is the only master on the controller's indirect register port. After a start pulse it runs a fixed series of register transactions. It keeps the controller's memory-configuration register, switches the controller into 64K addressing, and writes complementary bytes at one test location. It reads back that location and a second location 256 bytes higher. It then puts the configuration register back and reports a size code.

The test relies on address aliasing. With only 16K fitted, the two test locations reach the same cell, so both reads return the pattern that was just written. With 64K fitted, the two reads can differ. Two inverse patterns are used, so that a stray byte already sitting at the upper location cannot look like an alias. The memory-type bit that the controller reports is never used to decide the result.

Each port transaction names a register and carries a direction and a write byte. It is issued as a single-cycle strobe, and only after the port's status byte has shown its ready bit at 1. A poll that waits too long aborts the run with an error flag.

Top module: `probe_vram_sizer`

## Requirements
- R1: After reset, `done`, `err` and `port_req` are low and `size_code` is 0.
- R2: A run issues exactly 21 port transactions, in this order. Read register 28. Write 0x30 to register 28. Set the pointer (register 18 = 0x42, register 19 = 0x00) and write 0x55 to register 31. Set the pointer to 0x4200 and read 31. Set it to 0x4300 and read 31. Set it to 0x4200 and write 0xAA to 31. Set it to 0x4200 and read 31. Set it to 0x4300 and read 31. Write register 28 last.
- R3: The final transaction writes to register 28 the value read in the first transaction, ANDed with 0xF0.
- R4: The second transaction writes 0x30 to register 28, selecting 64K addressing before any data access.
- R5: `size_code` is 64 when the two first-pass reads differ. Otherwise it is 64 when the two second-pass reads differ. It is 16 only when both pairs match.
- R6: `port_req` rises only in the cycle after the sequencer sampled `port_stat[7]` = 1. It is never high in two consecutive cycles.
- R7: If `port_stat[7]` stays 0 for TIMEOUT_CYC cycles during one poll, the run stops with no further transactions. `done` pulses with `err` = 1 and `size_code` = 0.
- R8: A `start` pulse is accepted only while idle. A pulse during a run adds no transactions and no extra `done`. No transaction is issued while idle.
- R9: `done` is high for exactly one cycle, together with the final result. `size_code` and `err` then hold until the next accepted `start`, which clears both in the following cycle.
- R10: For a read transaction, `port_rdata` is sampled in the strobe cycle itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a probe run (idle only) |
| port_stat | input | 8 | Controller status byte, bit 7 = ready |
| port_rdata | input | 8 | Read data of the selected register |
| port_req | output | 1 | One-cycle transaction strobe |
| port_we | output | 1 | 1 = write, 0 = read |
| port_sel | output | 8 | Controller register number |
| port_wdata | output | 8 | Byte to write |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Run aborted on ready timeout |
| size_code | output | 7 | 16 or 64 after a good run, 0 otherwise |

## Verification
The bench targets a stale byte at the upper location that equals the first pattern. A design that stopped after the first pass would then report 16 on a 64K part. A controller model that aliases the two locations must give 16, and so must a stuck data path that reads back zero. A configuration read whose low nibble is set catches a missing 0xF0 mask in the restore write. A ready line that stalls part way through must end the run with an error after exactly the transactions issued so far; a design without the timeout would hang, and one that carried on would produce extra strobes. Ready held low for several cycles after each strobe, and a start pulse in the middle of a run, expose strobes issued without waiting and restarts that were not ignored.

// File: rtl/probe_pkg.sv
package probe_pkg;

   // total port transactions in one probe run
   localparam int unsigned NSTEP = 21;

   typedef enum logic [2:0] {
      CAP_NONE = 3'd0,
      CAP_SAVE = 3'd1,
      CAP_A    = 3'd2,
      CAP_B    = 3'd3,
      CAP_C    = 3'd4,
      CAP_D    = 3'd5
   } cap_e;

   typedef enum logic [1:0] {
      E_IDLE = 2'd0,
      E_WAIT = 2'd1,
      E_STRB = 2'd2
   } eng_e;

   typedef enum logic {
      S_IDLE = 1'b0,
      S_RUN  = 1'b1
   } seq_e;

endpackage

// File: rtl/probe_step_dec.sv
module probe_step_dec
   import probe_pkg::*;
#(
   parameter int unsigned STEP_W     = 5,
   parameter int unsigned SEL_W      = 8,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned REG_TYPE   = 28,
   parameter int unsigned REG_PTR_HI = 18,
   parameter int unsigned REG_PTR_LO = 19,
   parameter int unsigned REG_DATA   = 31,
   parameter logic [DATA_W-1:0] TYPE_64K = 8'h30,
   parameter logic [DATA_W-1:0] PAGE_A   = 8'h42,
   parameter logic [DATA_W-1:0] PAGE_B   = 8'h43,
   parameter logic [DATA_W-1:0] PTR_LOW  = 8'h00,
   parameter logic [DATA_W-1:0] PAT_A    = 8'h55,
   parameter logic [DATA_W-1:0] PAT_B    = 8'hAA
) (
   input  logic [STEP_W-1:0] step,
   output logic              op_we,
   output logic [SEL_W-1:0]  op_sel,
   output logic [DATA_W-1:0] op_wdata,
   output logic              op_use_saved,
   output cap_e              op_cap
);

   localparam logic [STEP_W-1:0] LAST = STEP_W'(NSTEP - 1);

   logic [STEP_W-1:0] rel;
   logic [STEP_W-1:0] grp;
   logic [STEP_W-1:0] pos;

   // steps 2..19 are six groups: pointer high, pointer low, data access
   always_comb begin
      rel          = step - STEP_W'(2);
      grp          = rel / STEP_W'(3);
      pos          = rel % STEP_W'(3);
      op_we        = 1'b0;
      op_sel       = SEL_W'(REG_TYPE);
      op_wdata     = '0;
      op_use_saved = 1'b0;
      op_cap       = CAP_NONE;
      if (step == STEP_W'(0)) begin
         op_cap = CAP_SAVE;
      end else if (step == STEP_W'(1)) begin
         op_we    = 1'b1;
         op_wdata = TYPE_64K;
      end else if (step == LAST) begin
         op_we        = 1'b1;
         op_use_saved = 1'b1;
      end else if (step < LAST) begin
         if (pos == STEP_W'(0)) begin
            op_we    = 1'b1;
            op_sel   = SEL_W'(REG_PTR_HI);
            op_wdata = (grp == STEP_W'(2) || grp == STEP_W'(5)) ? PAGE_B : PAGE_A;
         end else if (pos == STEP_W'(1)) begin
            op_we    = 1'b1;
            op_sel   = SEL_W'(REG_PTR_LO);
            op_wdata = PTR_LOW;
         end else begin
            op_sel = SEL_W'(REG_DATA);
            case (grp)
               STEP_W'(0): begin op_we = 1'b1; op_wdata = PAT_A; end
               STEP_W'(3): begin op_we = 1'b1; op_wdata = PAT_B; end
               STEP_W'(1): op_cap = CAP_A;
               STEP_W'(2): op_cap = CAP_B;
               STEP_W'(4): op_cap = CAP_C;
               default:    op_cap = CAP_D;
            endcase
         end
      end
   end

endmodule

// File: rtl/probe_port_eng.sv
module probe_port_eng
   import probe_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned RDY_BIT     = 7,
   parameter int unsigned TIMEOUT_CYC = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [DATA_W-1:0] stat,
   output logic              req,
   output logic              fin,
   output logic              tmo
);

   localparam int unsigned TMO_W = (TIMEOUT_CYC < 2) ? 1 : $clog2(TIMEOUT_CYC);
   localparam logic [TMO_W-1:0] POLL_LAST = TMO_W'(TIMEOUT_CYC - 1);

   eng_e             state;
   logic [TMO_W-1:0] poll_cnt;
   logic             rdy;
   logic             last_poll;

   assign rdy       = stat[RDY_BIT];
   assign last_poll = (poll_cnt == POLL_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= E_IDLE;
         poll_cnt <= '0;
      end else begin
         case (state)
            E_IDLE: begin
               if (go) begin
                  state    <= E_WAIT;
                  poll_cnt <= '0;
               end
            end
            E_WAIT: begin
               if (rdy)            state <= E_STRB;
               else if (last_poll) state <= E_IDLE;
               else                poll_cnt <= poll_cnt + TMO_W'(1);
            end
            default: state <= E_IDLE;
         endcase
      end
   end

   assign req = (state == E_STRB);
   assign fin = req;
   assign tmo = (state == E_WAIT) && !rdy && last_poll;

endmodule

// File: rtl/probe_verdict.sv
module probe_verdict
   import probe_pkg::*;
#(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned SIZE_W     = 7,
   parameter int unsigned SMALL_CODE = 16,
   parameter int unsigned LARGE_CODE = 64,
   parameter logic [DATA_W-1:0] SAVE_MASK = 8'hF0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_en,
   input  cap_e              cap_sel,
   input  logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] saved,
   output logic [SIZE_W-1:0] size
);

   localparam int unsigned NSLOT = 4;

   logic [DATA_W-1:0] slot [NSLOT];

   for (genvar i = 0; i < NSLOT; i++) begin : g_slot
      localparam cap_e TAG = cap_e'(3'(int'(CAP_A) + i));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          slot[i] <= '0;
         else if (cap_en && cap_sel == TAG)   slot[i] <= rdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              saved <= '0;
      else if (cap_en && cap_sel == CAP_SAVE)  saved <= rdata & SAVE_MASK;
   end

   // slots 0/1 are the first pass, 2/3 the second
   assign size = (slot[0] != slot[1] || slot[2] != slot[3])
                 ? SIZE_W'(LARGE_CODE) : SIZE_W'(SMALL_CODE);

endmodule

// File: rtl/probe_vram_sizer.sv
module probe_vram_sizer
   import probe_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SEL_W       = 8,
   parameter int unsigned SIZE_W      = 7,
   parameter int unsigned RDY_BIT     = 7,
   parameter int unsigned TIMEOUT_CYC = 64,
   parameter int unsigned SMALL_CODE  = 16,
   parameter int unsigned LARGE_CODE  = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] port_stat,
   input  logic [DATA_W-1:0] port_rdata,
   output logic              port_req,
   output logic              port_we,
   output logic [SEL_W-1:0]  port_sel,
   output logic [DATA_W-1:0] port_wdata,
   output logic              done,
   output logic              err,
   output logic [SIZE_W-1:0] size_code
);

   localparam int unsigned STEP_W = $clog2(NSTEP);
   localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(NSTEP - 1);

   if (TIMEOUT_CYC < 2) begin : g_bad_tmo
      $error("TIMEOUT_CYC must be at least 2");
   end
   if (RDY_BIT >= DATA_W) begin : g_bad_rdy
      $error("RDY_BIT outside the status byte");
   end
   if (LARGE_CODE >= (1 << SIZE_W) || SMALL_CODE >= (1 << SIZE_W)) begin : g_bad_size
      $error("SIZE_W too narrow for the size codes");
   end
   if (DATA_W != 8) begin : g_bad_data
      $error("the probe sequence is defined for byte registers");
   end

   seq_e              state;
   logic [STEP_W-1:0] step;
   logic              busy;
   logic              eng_fin;
   logic              eng_tmo;
   logic              op_we;
   logic [SEL_W-1:0]  op_sel;
   logic [DATA_W-1:0] op_wdata;
   logic              op_use_saved;
   cap_e              op_cap;
   logic [DATA_W-1:0] saved;
   logic [SIZE_W-1:0] verdict;

   assign busy = (state == S_RUN);

   probe_step_dec #(
      .STEP_W (STEP_W),
      .SEL_W  (SEL_W),
      .DATA_W (DATA_W)
   ) u_dec (
      .step         (step),
      .op_we        (op_we),
      .op_sel       (op_sel),
      .op_wdata     (op_wdata),
      .op_use_saved (op_use_saved),
      .op_cap       (op_cap)
   );

   probe_port_eng #(
      .DATA_W      (DATA_W),
      .RDY_BIT     (RDY_BIT),
      .TIMEOUT_CYC (TIMEOUT_CYC)
   ) u_eng (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (busy),
      .stat  (port_stat),
      .req   (port_req),
      .fin   (eng_fin),
      .tmo   (eng_tmo)
   );

   probe_verdict #(
      .DATA_W     (DATA_W),
      .SIZE_W     (SIZE_W),
      .SMALL_CODE (SMALL_CODE),
      .LARGE_CODE (LARGE_CODE)
   ) u_verdict (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap_en  (eng_fin),
      .cap_sel (op_cap),
      .rdata   (port_rdata),
      .saved   (saved),
      .size    (verdict)
   );

   assign port_we    = op_we;
   assign port_sel   = op_sel;
   assign port_wdata = op_use_saved ? saved : op_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         step      <= '0;
         done      <= 1'b0;
         err       <= 1'b0;
         size_code <= '0;
      end else begin
         done <= 1'b0;
         case (state)
            S_IDLE: begin
               if (start) begin
                  state     <= S_RUN;
                  step      <= '0;
                  err       <= 1'b0;
                  size_code <= '0;
               end
            end
            default: begin
               if (eng_tmo) begin
                  state <= S_IDLE;
                  done  <= 1'b1;
                  err   <= 1'b1;
               end else if (eng_fin) begin
                  if (step == STEP_LAST) begin
                     state     <= S_IDLE;
                     done      <= 1'b1;
                     size_code <= verdict;
                  end else begin
                     step <= step + STEP_W'(1);
                  end
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/probe_chk.sv
module probe_chk #(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned SIZE_W     = 7,
   parameter int unsigned RDY_BIT    = 7,
   parameter int unsigned SMALL_CODE = 16,
   parameter int unsigned LARGE_CODE = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [DATA_W-1:0] port_stat,
   input logic              port_req,
   input logic              done,
   input logic              err,
   input logic [SIZE_W-1:0] size_code,
   input logic              busy
);

   // R6
   req_after_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      port_req |-> $past(port_stat[RDY_BIT]));

   // R6
   req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      port_req |=> !port_req);

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   size_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!done && !$past(start)) |-> $stable(size_code));

   // R5
   size_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !err) |-> (size_code == SIZE_W'(SMALL_CODE) || size_code == SIZE_W'(LARGE_CODE)));

   // R7
   err_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err) |-> (size_code == '0));

   // R8
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !port_req);

endmodule

bind probe_vram_sizer probe_chk #(
   .DATA_W     (DATA_W),
   .SIZE_W     (SIZE_W),
   .RDY_BIT    (RDY_BIT),
   .SMALL_CODE (SMALL_CODE),
   .LARGE_CODE (LARGE_CODE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .port_stat (port_stat),
   .port_req  (port_req),
   .done      (done),
   .err       (err),
   .size_code (size_code),
   .busy      (busy)
);

// File: tb/sim_probe_vram_sizer.sv
`timescale 1ns/1ps
module sim_probe_vram_sizer;

   localparam int CLK_NS  = 10;
   localparam int TMO     = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [7:0] port_stat;
   logic [7:0] port_rdata = 8'h00;
   logic       port_req;
   logic       port_we;
   logic [7:0] port_sel;
   logic [7:0] port_wdata;
   logic       done;
   logic       err;
   logic [6:0] size_code;

   always #(CLK_NS/2) clk = ~clk;

   probe_vram_sizer #(.TIMEOUT_CYC(TMO)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start),
      .port_stat(port_stat), .port_rdata(port_rdata),
      .port_req(port_req), .port_we(port_we), .port_sel(port_sel),
      .port_wdata(port_wdata), .done(done), .err(err), .size_code(size_code)
   );

   int total = 0;
   int bad   = 0;

   task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", rq, what, act, exp);
      end
   endtask

   // ---------------- controller model ----------------
   logic [7:0]  mregs [0:31];
   logic [7:0]  vram [int unsigned];
   logic [15:0] ptr = 16'h0000;
   int          busy_left = 0;
   int          busy_n = 0;
   int          acc_seen = 0;
   int          acc_base = 0;
   int          stall_at = -1;
   bit          small_ram = 0;
   bit          stuck = 0;

   function automatic int unsigned vmap(input logic [15:0] a);
      return small_ram ? 32'(a & 16'h3EFF) : 32'(a);
   endfunction

   function automatic logic [7:0] vget(input int unsigned a);
      return vram.exists(a) ? vram[a] : 8'h00;
   endfunction

   assign port_stat = {(busy_left == 0) && !(stall_at >= 0 && (acc_seen - acc_base) >= stall_at), 7'h00};

   always @(negedge clk) begin
      if (port_sel == 8'd31)      port_rdata <= stuck ? 8'h00 : vget(vmap(ptr));
      else if (port_sel == 8'd28) port_rdata <= mregs[28] | 8'h0F;
      else                        port_rdata <= mregs[port_sel[4:0]];
   end

   always @(posedge clk) begin
      if (port_req) begin
         acc_seen  <= acc_seen + 1;
         busy_left <= busy_n;
         if (port_we) begin
            if (port_sel == 8'd18)      ptr[15:8] <= port_wdata;
            else if (port_sel == 8'd19) ptr[7:0]  <= port_wdata;
            else if (port_sel == 8'd31) begin
               vram[vmap(ptr)] = port_wdata;
               ptr <= ptr + 16'd1;
            end else mregs[port_sel[4:0]] = port_wdata;
         end else if (port_sel == 8'd31) ptr <= ptr + 16'd1;
      end else if (busy_left > 0) busy_left <= busy_left - 1;
   end

   // ---------------- scoreboard ----------------
   typedef struct {
      bit    we;
      int    sel;
      int    wdata;
      string tag;
   } exp_t;

   exp_t exp_q [$];
   bit   prev_rdy = 1'b0;
   int   done_cnt = 0;

   task automatic push_acc(input bit we, input int sel, input int wdata, input string tag);
      exp_t e;
      e.we = we; e.sel = sel; e.wdata = wdata; e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic push_ptr(input int page);
      push_acc(1, 18, page, "R2");
      push_acc(1, 19, 8'h00, "R2");
   endtask

   // driver: expected transaction list of one run
   task automatic push_run(input int restore);
      push_acc(0, 28, 0, "R2");
      push_acc(1, 28, 8'h30, "R4");
      push_ptr(8'h42); push_acc(1, 31, 8'h55, "R2");
      push_ptr(8'h42); push_acc(0, 31, 0, "R2");
      push_ptr(8'h43); push_acc(0, 31, 0, "R2");
      push_ptr(8'h42); push_acc(1, 31, 8'hAA, "R2");
      push_ptr(8'h42); push_acc(0, 31, 0, "R2");
      push_ptr(8'h43); push_acc(0, 31, 0, "R2");
      push_acc(1, 28, restore, "R3");
   endtask

   // monitor
   always @(negedge clk) begin
      if (rst_n && port_req) begin
         chk(prev_rdy, "R6", "strobe without ready", 0, 1);
         if (exp_q.size() == 0) begin
            chk(0, "R8", "unexpected transaction sel", int'(port_sel), -1);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(port_we == e.we && int'(port_sel) == e.sel, e.tag, "transaction reg/dir",
                {port_we, port_sel}, {e.we, 8'(e.sel)});
            if (e.we) chk(int'(port_wdata) == e.wdata, e.tag, "write data", int'(port_wdata), e.wdata);
         end
      end
      if (rst_n && done) done_cnt++;
      prev_rdy = port_stat[7];
   end

   // ---------------- one probe run ----------------
   task automatic run_probe(input bit sm, input bit st, input logic [7:0] pre, input logic [7:0] init28,
                            input int bn, input int stall, input bit extra_start);
      int          dc0;
      int          exp_size;
      logic [7:0]  a, b, c, d;
      bit          exp_err;
      bit          seen;
      logic [6:0]  held;
      small_ram = sm; stuck = st; busy_n = bn;
      vram.delete();
      vram[vmap(16'h4300)] = pre;
      mregs[28] = init28;
      exp_err = (stall >= 0);
      if (st)       begin a = 0; b = 0; c = 0; d = 0; end
      else if (sm)  begin a = 8'h55; b = 8'h55; c = 8'hAA; d = 8'hAA; end
      else          begin a = 8'h55; b = pre; c = 8'hAA; d = pre; end
      exp_size = exp_err ? 0 : ((a != b) ? 64 : ((c != d) ? 64 : 16));
      push_run(int'(init28 & 8'hF0));
      @(negedge clk);
      acc_base = acc_seen;
      stall_at = stall;
      dc0 = done_cnt;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      // R9: accepted start clears the previous result
      chk(size_code == 7'd0 && err == 1'b0, "R9", "result cleared on start", int'(size_code), 0);
      seen = 0;
      for (int cyc = 0; cyc < 5000; cyc++) begin
         if (done) begin seen = 1; break; end
         if (extra_start && cyc == 15) start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      chk(seen, "R9", "done seen", int'(seen), 1);
      chk(err == exp_err, "R7", "err flag", int'(err), int'(exp_err));
      chk(int'(size_code) == exp_size, exp_err ? "R7" : "R5", "size code", int'(size_code), exp_size);
      if (exp_err) begin
         chk((acc_seen - acc_base) == stall, "R7", "transactions before abort", acc_seen - acc_base, stall);
         exp_q.delete();
      end else begin
         chk(mregs[28] == (init28 & 8'hF0), "R3", "config register restored", int'(mregs[28]), int'(init28 & 8'hF0));
         chk(exp_q.size() == 0, "R2", "transactions left", exp_q.size(), 0);
      end
      held = size_code;
      @(negedge clk);
      chk(done == 1'b0, "R9", "done width", int'(done), 0);
      repeat (8) @(negedge clk);
      chk(size_code == held, "R9", "size holds", int'(size_code), int'(held));
      chk(done_cnt - dc0 == 1, "R8", "done pulses per run", done_cnt - dc0, 1);
      stall_at = -1;
   endtask

   initial begin
      for (int i = 0; i < 32; i++) mregs[i] = 8'h00;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk(done == 0 && err == 0 && port_req == 0 && size_code == 0, "R1", "reset state",
          {done, err, port_req, size_code}, 0);
      // R5 R10 large part, distinct stale byte
      run_probe(0, 0, 8'h3C, 8'h2A, 0, -1, 0);
      // R5 aliased small part, slow ready
      run_probe(1, 0, 8'h00, 8'hE5, 2, -1, 0);
      // R5 stale byte equals first pattern: second pass decides
      run_probe(0, 0, 8'h55, 8'h10, 1, -1, 0);
      // R5 stuck data path reads zero
      run_probe(0, 1, 8'h00, 8'h7F, 0, -1, 0);
      // R8 start during a run, R6 long busy
      run_probe(0, 0, 8'hAA, 8'h9B, 3, -1, 1);
      // R7 ready stalls after 7 transactions
      run_probe(0, 0, 8'h00, 8'h30, 1, 7, 0);
      // recovery after abort
      run_probe(1, 0, 8'h00, 8'h44, 0, -1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule